// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous Memory

This block models a single-port synchronous memory that shares one 18-bit data bus for reads and writes. It accepts one operation on every clock and needs no idle cycles when the traffic switches between reads and writes. Address, operation type, byte selects and the three chip enables are registered on the rising edge. Read data comes out of an output register one enabled clock after its address. Write data follows its address by two enabled clocks. Because a write's data slot lines up with the slot a read uses for its output, any mix of reads and writes keeps the bus busy on every cycle. An active-low clock enable freezes the whole pipeline. The block produces a bus drive enable that combines the internal direction logic with an asynchronous active-low output enable.

Each 18-bit word is split into two lanes of nine bits. Each lane holds one byte and one parity bit. Each lane has its own active-low byte select. An external sequencer supplies every address, including the addresses inside a burst. The advance input only tells the block to repeat the previous operation type. The tristate bus is modelled as separate input data, output data and drive-enable ports.

Top module: `zt_sram`

## Requirements
- R1: A new operation starts at an enabled rising edge (`clk_en_n`=0) when `adv_ld_n`=0 and the chip is selected, which means `ce1_n`=0, `ce2`=1 and `ce3_n`=0. `we_n`=0 makes it a write and `we_n`=1 makes it a read.
- R2: At a rising edge with `clk_en_n`=1, no state changes: memory, pipeline, `dout` and the internal drive permission all hold.
- R3: For a read started at enabled edge N, `dout` holds the addressed word after enabled edge N+1. `drive_en` is high until the next enabled edge, provided `oe_n`=0.
- R4: For a write started at enabled edge N, `din` is sampled at enabled edge N+2 and stored at the address given at edge N.
- R5: The word layout is: lane 0 = bits 7:0 plus bit 16, and lane 1 = bits 15:8 plus bit 17. `bws_n[0]`=0 writes lane 0 and `bws_n[1]`=0 writes lane 1. The selects are taken at the same edge as the address. A lane that is not selected keeps its old value, so `bws_n`=2'b11 writes nothing.
- R6: Deselect is pipelined. Suppose an enabled edge loads (`adv_ld_n`=0) with any chip enable inactive. Then `drive_en` is low after the following enabled edge.
- R7: `drive_en` is low, whatever `oe_n` is, in the data cycle of a write and in the first cycle after a deselect.
- R8: `oe_n` acts combinationally and is active low. `oe_n`=1 forces `drive_en` low. `oe_n`=0 can only raise `drive_en` in cycles where R3 allows it.
- R9: Suppose a read's address matches the write whose data is sampled at the same enabled edge. That read returns the new lanes merged with the old unselected lanes, and this covers a read issued right after a write.
- R10: At an enabled edge with `adv_ld_n`=1, `ce1_n`, `ce2`, `ce3_n` and `we_n` are ignored. The previous operation type repeats with the new `addr` and `bws_n`. If the previous slot was a deselect, the block stays deselected.
- R11: A synchronous active-high `rst` empties the pipeline. After a reset edge the block is deselected, `drive_en` is low and `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock qualifier; high stalls everything |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld_n | input | 1 | Low loads a new operation; high repeats the previous type |
| we_n | input | 1 | Low selects write, high selects read |
| bws_n | input | 2 | Active-low lane write selects |
| addr | input | AW | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | 18 | Bus data into the block |
| dout | output | 18 | Output register contents |
| drive_en | output | 1 | High when the block drives the bus |

## Verification
The bench goes after read-after-write at distance one, where a design without the forwarding merge would return the stale word. It checks partial-lane writes, where a mask applied at the wrong stage or to the wrong bit would corrupt the parity bits. Stalls land in the middle of write pipelines, where a design that counted raw clocks instead of enabled ones would sample write data from the wrong cycle. Bursts run with the chip enables and `we_n` toggling, which exposes a design that re-decodes them during advance. Deselect, write-data cycles and output-enable toggles check that `drive_en` never rises outside a read's data cycle.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    localparam int LANES  = 2;
    localparam int BYTE_W = 8;
    localparam int LANE_W = BYTE_W + 1;
    localparam int DW     = LANES * LANE_W;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // lane g = {parity bit, data byte}
    function automatic logic [LANE_W-1:0] lane_get(input logic [DW-1:0] d, input int g);
        return {d[LANES*BYTE_W + g], d[g*BYTE_W +: BYTE_W]};
    endfunction

endpackage

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
    import zt_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              sel,
    input  logic              adv_ld_n,
    input  logic              we_n,
    input  logic [AW-1:0]     addr,
    input  logic [LANES-1:0]  bws_n,
    output op_e               s1_op,
    output logic [AW-1:0]     s1_addr,
    output op_e               s2_op,
    output logic [AW-1:0]     s2_addr,
    output logic [LANES-1:0]  s2_bws_n
);

    logic [LANES-1:0] s1_bws_n;
    op_e              nxt_op;

    always_comb begin
        if (!adv_ld_n) begin
            if (sel) nxt_op = we_n ? OP_READ : OP_WRITE;
            else     nxt_op = OP_NONE;
        end else begin
            nxt_op = s1_op;     // burst continuation keeps the type
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_op    <= OP_NONE;
            s2_op    <= OP_NONE;
            s1_addr  <= '0;
            s2_addr  <= '0;
            s1_bws_n <= '1;
            s2_bws_n <= '1;
        end else if (step) begin
            s2_op    <= s1_op;
            s2_addr  <= s1_addr;
            s2_bws_n <= s1_bws_n;
            s1_op    <= nxt_op;
            s1_addr  <= addr;
            s1_bws_n <= bws_n;
        end
    end

endmodule

// File: rtl/zt_store.sv
module zt_store
    import zt_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [LANES-1:0]  wr_bws_n,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data
);

    localparam int DEPTH = 1 << AW;

    logic             hit;
    logic [LANE_W-1:0] rd_lane [LANES];

    assign hit = wr_en && (wr_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];
        logic [LANE_W-1:0] wr_lane;

        assign wr_lane = lane_get(wr_data, g);

        always_ff @(posedge clk) begin
            if (wr_en && !wr_bws_n[g]) mem_q[wr_addr] <= wr_lane;
        end

        assign rd_lane[g] = (hit && !wr_bws_n[g]) ? wr_lane : mem_q[rd_addr];
    end

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < LANES; g++) begin
            rd_data[g*BYTE_W +: BYTE_W]  = rd_lane[g][BYTE_W-1:0];
            rd_data[LANES*BYTE_W + g]    = rd_lane[g][BYTE_W];
        end
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              adv_ld_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  bws_n,
    input  logic [AW-1:0]     addr,
    input  logic              oe_n,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    output logic              drive_en
);

    logic              step;
    logic              sel;
    op_e               s1_op;
    op_e               s2_op;
    logic [AW-1:0]     s1_addr;
    logic [AW-1:0]     s2_addr;
    logic [LANES-1:0]  s2_bws_n;
    logic              wr_en;
    logic [DW-1:0]     rd_data;

    assign step = !clk_en_n;
    assign sel  = !ce1_n && ce2 && !ce3_n;

    zt_cmd_pipe #(.AW(AW)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .sel      (sel),
        .adv_ld_n (adv_ld_n),
        .we_n     (we_n),
        .addr     (addr),
        .bws_n    (bws_n),
        .s1_op    (s1_op),
        .s1_addr  (s1_addr),
        .s2_op    (s2_op),
        .s2_addr  (s2_addr),
        .s2_bws_n (s2_bws_n)
    );

    assign wr_en = step && (s2_op == OP_WRITE);

    zt_store #(.AW(AW)) u_store (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_addr  (s2_addr),
        .wr_bws_n (s2_bws_n),
        .wr_data  (din),
        .rd_addr  (s1_addr),
        .rd_data  (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst)                             dout <= '0;
        else if (step && s1_op == OP_READ)   dout <= rd_data;
    end

    assign drive_en = (s2_op == OP_READ) && !oe_n;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
    import zt_sram_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          clk_en_n,
    input logic          ce1_n,
    input logic          ce2,
    input logic          ce3_n,
    input logic          adv_ld_n,
    input logic          we_n,
    input logic          oe_n,
    input logic [DW-1:0] dout,
    input logic          drive_en,
    input op_e           s2_op
);

    logic chip_on;
    assign chip_on = !ce1_n && ce2 && !ce3_n;

    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> $stable(dout));

    assert_read_stage_R3: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !adv_ld_n && chip_on && we_n) ##1 !clk_en_n |=> (s2_op == OP_READ));

    assert_deselect_R6: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !adv_ld_n && !chip_on) ##1 !clk_en_n |=> !drive_en);

    assert_write_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (s2_op == OP_WRITE) |-> !drive_en);

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !drive_en);

    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> (!drive_en && dout == '0));

endmodule

bind zt_sram zt_sram_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_en_n (clk_en_n),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .adv_ld_n (adv_ld_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .dout     (dout),
    .drive_en (drive_en),
    .s2_op    (s2_op)
);

// File: tb/sim_zt_sram.sv
module sim_zt_sram;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [2:0] SEL = 3'b010;   // {ce1_n, ce2, ce3_n}
    localparam logic [2:0] DS1 = 3'b110;
    localparam logic [2:0] DS2 = 3'b000;
    localparam logic [2:0] DS3 = 3'b011;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en_n = 1'b0;
    logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic          adv_ld_n = 1'b0, we_n = 1'b1, oe_n = 1'b0;
    logic [1:0]    bws_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [17:0]   din = '0;
    logic [17:0]   dout;
    logic          drive_en;

    always #2 clk = ~clk;

    zt_sram #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adv_ld_n(adv_ld_n), .we_n(we_n), .bws_n(bws_n),
        .addr(addr), .oe_n(oe_n), .din(din), .dout(dout), .drive_en(drive_en)
    );

    // behavioural reference: a list of pending operations, newest first
    typedef struct { int op; int a; logic [1:0] bw; } pend_t;  // op: 0 none, 1 read, 2 write
    pend_t       pend[$];
    logic [17:0] ref_mem [DEPTH];
    logic [17:0] exp_q = '0;
    bit          exp_rd = 1'b0;
    int          checks = 0, errs = 0, cycles = 0;
    string       tag = "R11";
    bit          done = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            pend.delete();
            exp_rd = 1'b0;
            exp_q  = '0;
        end else if (!clk_en_n) begin
            pend_t n;
            int    prev;
            if (pend.size() > 1 && pend[1].op == 2) begin
                if (!pend[1].bw[0]) begin
                    ref_mem[pend[1].a][7:0] = din[7:0];
                    ref_mem[pend[1].a][16]  = din[16];
                end
                if (!pend[1].bw[1]) begin
                    ref_mem[pend[1].a][15:8] = din[15:8];
                    ref_mem[pend[1].a][17]   = din[17];
                end
            end
            if (pend.size() > 0 && pend[0].op == 1) exp_q = ref_mem[pend[0].a];
            prev = (pend.size() > 0) ? pend[0].op : 0;
            if (!adv_ld_n)
                n.op = (!ce1_n && ce2 && !ce3_n) ? (we_n ? 1 : 2) : 0;
            else
                n.op = prev;
            n.a  = int'(addr);
            n.bw = bws_n;
            pend.push_front(n);
            if (pend.size() > 2) void'(pend.pop_back());
            exp_rd = (pend.size() > 1) && (pend[1].op == 1);
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    task automatic compare();
        checks++;
        if (drive_en !== (exp_rd && !oe_n)) begin
            errs++;
            $display("FAIL %s drive_en actual=%b expected=%b", tag, drive_en, exp_rd && !oe_n);
        end
        if (exp_rd || rst) begin
            checks++;
            if (dout !== exp_q) begin
                errs++;
                $display("FAIL %s dout actual=%h expected=%h", tag, dout, exp_q);
            end
        end
    endtask

    task automatic cyc(input logic cen, input logic [2:0] ce, input logic adv,
                       input logic we, input logic [1:0] bw, input int a, input logic oe);
        clk_en_n = cen;
        {ce1_n, ce2, ce3_n} = ce;
        adv_ld_n = adv;
        we_n     = we;
        bws_n    = bw;
        addr     = AW'(a);
        oe_n     = oe;
        din      = 18'($urandom);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input int a, input logic [1:0] bw);
        cyc(1'b0, SEL, 1'b0, 1'b0, bw, a, 1'b0);
    endtask

    task automatic rd(input int a);
        cyc(1'b0, SEL, 1'b0, 1'b1, 2'b11, a, 1'b0);
    endtask

    task automatic idle();
        cyc(1'b0, DS1, 1'b0, 1'b1, 2'b11, 0, 1'b0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<=20000 cycles", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        // R11: reset puts the block deselected with the bus released
        tag = "R11";
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc(1'b0, SEL, 1'b0, 1'b1, 2'b11, i, 1'b0);
        rst = 1'b0;
        idle();

        // R1 / R4: full-word writes back to back over the whole array
        tag = "R4";
        for (int i = 0; i < DEPTH; i++) wr(i, 2'b00);
        idle(); idle();

        // R3: back-to-back reads
        tag = "R3";
        for (int i = 0; i < 32; i++) rd(i * 7 % DEPTH);
        idle(); idle();

        // R1: alternating write and read, other addresses
        tag = "R1";
        for (int i = 0; i < 16; i++) begin
            wr(40 + i, 2'b00);
            rd(100 + i);
        end
        idle(); idle();

        // R9: read immediately after a write to the same address
        tag = "R9";
        for (int i = 0; i < 8; i++) begin
            wr(5, (i % 2 == 0) ? 2'b00 : 2'b10);
            rd(5);
        end
        wr(9, 2'b01); rd(9); rd(9);
        idle(); idle();

        // R5: single-lane writes and a no-lane write, then read back
        tag = "R5";
        wr(20, 2'b10); wr(21, 2'b01); wr(22, 2'b11); wr(23, 2'b00);
        rd(20); rd(21); rd(22); rd(23);
        idle(); idle();

        // R2: stalls in the middle of write and read pipelines
        tag = "R2";
        wr(30, 2'b00);
        cyc(1'b1, SEL, 1'b0, 1'b0, 2'b00, 31, 1'b0);
        cyc(1'b1, DS1, 1'b0, 1'b1, 2'b00, 32, 1'b0);
        rd(30);
        cyc(1'b1, SEL, 1'b0, 1'b0, 2'b00, 30, 1'b0);
        rd(31);
        cyc(1'b1, SEL, 1'b1, 1'b0, 2'b00, 30, 1'b0);
        cyc(1'b1, SEL, 1'b0, 1'b0, 2'b00, 30, 1'b0);
        idle(); idle(); idle();

        // R10: burst read with enables and we_n toggling during advance
        tag = "R10";
        rd(60);
        cyc(1'b0, DS2, 1'b1, 1'b0, 2'b00, 61, 1'b0);
        cyc(1'b0, DS3, 1'b1, 1'b0, 2'b00, 62, 1'b0);
        cyc(1'b0, SEL, 1'b1, 1'b0, 2'b00, 63, 1'b0);
        // burst write with we_n high during advance
        wr(70, 2'b00);
        cyc(1'b0, DS1, 1'b1, 1'b1, 2'b01, 71, 1'b0);
        cyc(1'b0, SEL, 1'b1, 1'b1, 2'b10, 72, 1'b0);
        // advance after a deselect stays deselected
        idle();
        cyc(1'b0, SEL, 1'b1, 1'b1, 2'b11, 73, 1'b0);
        cyc(1'b0, SEL, 1'b1, 1'b0, 2'b00, 74, 1'b0);
        rd(70); rd(71); rd(72); rd(74);
        idle(); idle();

        // R6: deselect through each enable, each releases the bus
        tag = "R6";
        rd(1); cyc(1'b0, DS2, 1'b0, 1'b1, 2'b11, 2, 1'b0);
        rd(2); cyc(1'b0, DS3, 1'b0, 1'b1, 2'b11, 3, 1'b0);
        rd(3); idle(); idle();

        // R7: write data cycles and first cycle after deselect
        tag = "R7";
        idle(); rd(4); wr(4, 2'b00); rd(4); wr(6, 2'b00); wr(7, 2'b00); rd(6);
        idle(); idle();

        // R8: output enable gates the bus combinationally
        tag = "R8";
        for (int i = 0; i < 12; i++)
            cyc(1'b0, SEL, 1'b0, 1'b1, 2'b11, 80 + i, logic'(i % 3 == 1));
        idle(); idle();

        // mixed traffic over a small address range
        tag = "R9";
        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 99);
            cyc(logic'(r < 15), (r % 11 == 0) ? DS1 : SEL, logic'(r % 5 == 0),
                logic'(r % 2), 2'($urandom), $urandom_range(0, 7), logic'(r % 9 == 0));
        end
        idle(); idle();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule